// File: doc/BRIEF.md
# Scaled FP4 to BF16 Unpacker

This streaming block takes in bytes that each carry two packed 4-bit floating-point codes, together with one 8-bit exponent scale that applies to both codes of that byte. For every code it emits one 16-bit bfloat16 word. The code in the low nibble is emitted before the code in the high nibble. Each code holds a sign, a two-bit exponent and a single mantissa bit. The exponent is moved into bfloat16 range by adding a fixed offset, then the scale is added, and the result saturates at the largest exponent value.

Both the input and the output use a valid/ready handshake. The block stores one accepted byte and its scale, then steps through the codes of that byte one per output transfer. It takes no new byte while codes of the current byte are still waiting. It can take the next byte in the same cycle that the last code leaves, so a stream with no back-pressure runs at one output word per cycle. The code has no zero, infinity or NaN encoding, and the block does no arithmetic on the results.

Top module: `fp4s_bf16_unpack`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid goes to 0 and any held byte is dropped. After reset, in_ready is 1 and out_valid is 0.
- R2: Each accepted byte yields its code from bits [3:0] first and its code from bits [7:4] second.
- R3: Bit 15 of out_word equals bit 3 of the code being emitted.
- R4: out_word[14:7] equals code bits [2:1] plus 126 plus in_scale, where in_scale is taken as unsigned.
- R5: out_word[6] equals bit 0 of the code. out_word[5:0] is always zero.
- R6: A code exponent field of 0 gets no special treatment. Code 4'b0000 with scale 0 gives 16'h3F00.
- R7: When the R4 sum is greater than 255, out_word[14:7] is 255. For example, byte 8'hFF with scale 255 gives 16'hFFC0.
- R8: Once a byte is accepted, in_ready stays low until the transfer of that byte's last code. It can be high in the cycle of that last transfer, but only when out_ready is high.
- R9: While out_valid is high and out_ready is low, out_valid and out_word keep their values.
- R10: Each accepted byte produces exactly two output transfers, and no output transfer occurs without an accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | in_byte and in_scale hold a byte to be accepted |
| in_ready | output | 1 | The block can accept a byte in this cycle |
| in_byte | input | 8 | Two packed codes; the low nibble is emitted first |
| in_scale | input | 8 | Unsigned exponent offset for both codes of the byte |
| out_valid | output | 1 | out_word holds a decoded word |
| out_ready | input | 1 | The receiver takes out_word in this cycle |
| out_word | output | 16 | Decoded bfloat16 bit pattern |

## Verification
Two situations are hard to reach from the ports. The first is the cycle in which the second code of a byte leaves and the next byte arrives at the same time. The second is a long stall on the first code of a byte while the next byte is already waiting at the input. The bench covers the first case by keeping in_valid high across a sweep of all 256 byte values while out_ready stays high, which forces a new byte in on every second-code transfer. It covers the second case by holding out_ready low, checking that in_ready stays low and that out_word holds its value, and then running a sweep with pseudo-random back-pressure. A scale sweep crosses the saturation point, so the clamp is reached both from the exponent field and from the scale.

// File: rtl/fp4s_pkg.sv
package fp4s_pkg;

    localparam int FP4_EXP_W  = 2;
    localparam int BF16_EXP_W = 8;
    localparam int BF16_MAN_W = 7;

    // Fields of one packed 4-bit code, most significant first
    typedef struct packed {
        logic                 sign;
        logic [FP4_EXP_W-1:0] exp;
        logic                 man;
    } fp4_code_t;

    // bfloat16 bit pattern
    typedef struct packed {
        logic                  sign;
        logic [BF16_EXP_W-1:0] exp;
        logic [BF16_MAN_W-1:0] man;
    } bf16_word_t;

endpackage

// File: rtl/fp4s_code_pick.sv
module fp4s_code_pick
    import fp4s_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CODE_W = 4,
    parameter int SEL_W  = 1
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [SEL_W-1:0]  sel_i,
    output fp4_code_t         code_o
);
    localparam int N_CODES = DATA_W / CODE_W;
    localparam int FIELD_W = $bits(fp4_code_t);

    logic [CODE_W-1:0] lane [N_CODES];

    // Lane i is bits [CODE_W*i +: CODE_W]; lane 0 is the low nibble
    for (genvar i = 0; i < N_CODES; i++) begin : g_lane
        assign lane[i] = data_i[i*CODE_W +: CODE_W];
    end

    always_comb begin
        code_o = '0;
        for (int i = 0; i < N_CODES; i++) begin
            if (sel_i == SEL_W'(i)) begin
                code_o = lane[i][FIELD_W-1:0];
            end
        end
    end

endmodule

// File: rtl/fp4s_exp_rebase.sv
module fp4s_exp_rebase
    import fp4s_pkg::*;
#(
    parameter int SCALE_W  = 8,
    parameter int EXP_BIAS = 126,
    parameter int EXP_MAX  = 255
) (
    input  logic [FP4_EXP_W-1:0]  code_exp_i,
    input  logic [SCALE_W-1:0]    scale_i,
    output logic [BF16_EXP_W-1:0] exp_o,
    output logic                  sat_o
);
    // Two spare bits above the widest operand so the sum never wraps
    localparam int WIDE_W = (SCALE_W > BF16_EXP_W) ? SCALE_W : BF16_EXP_W;
    localparam int SUM_W  = WIDE_W + 2;

    logic [SUM_W-1:0] sum_d;

    always_comb begin
        sum_d = SUM_W'(EXP_BIAS) + SUM_W'(code_exp_i) + SUM_W'(scale_i);
        sat_o = (sum_d > SUM_W'(EXP_MAX));
        exp_o = sat_o ? BF16_EXP_W'(EXP_MAX) : sum_d[BF16_EXP_W-1:0];
    end

endmodule

// File: rtl/fp4s_beat_ctrl.sv
module fp4s_beat_ctrl #(
    parameter int DATA_W  = 8,
    parameter int SCALE_W = 8,
    parameter int N_CODES = 2,
    parameter int SEL_W   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid_i,
    output logic               in_ready_o,
    input  logic [DATA_W-1:0]  data_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic               out_valid_o,
    input  logic               out_ready_i,
    output logic [DATA_W-1:0]  data_o,
    output logic [SCALE_W-1:0] scale_o,
    output logic [SEL_W-1:0]   sel_o
);
    typedef struct packed {
        logic               full;
        logic [SEL_W-1:0]   sel;
        logic [DATA_W-1:0]  data;
        logic [SCALE_W-1:0] scale;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  last, take, accept;

    always_comb begin
        last       = (ctrl_q.sel == SEL_W'(N_CODES - 1));
        take       = ctrl_q.full && out_ready_i;
        in_ready_o = !ctrl_q.full || (take && last);
        accept     = in_valid_i && in_ready_o;

        ctrl_d = ctrl_q;
        if (take) begin
            if (last) begin
                ctrl_d.full = 1'b0;
                ctrl_d.sel  = '0;
            end else begin
                ctrl_d.sel = ctrl_q.sel + 1'b1;
            end
        end
        if (accept) begin
            ctrl_d.full  = 1'b1;
            ctrl_d.sel   = '0;
            ctrl_d.data  = data_i;
            ctrl_d.scale = scale_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign out_valid_o = ctrl_q.full;
    assign data_o      = ctrl_q.data;
    assign scale_o     = ctrl_q.scale;
    assign sel_o       = ctrl_q.sel;

    // R2: a fresh byte always starts at code 0
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> (out_valid_o && sel_o == '0));

    // R10: a transfer that is not the last one leaves more to send
    p_more_beats_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i && sel_o != SEL_W'(N_CODES - 1)) |=> out_valid_o);

    if (N_CODES > 1) begin : g_busy_chk
        // R8: the cycle after acceptance the input is closed
        p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid_i && in_ready_o) |=> !in_ready_o);
    end

endmodule

// File: rtl/fp4s_bf16_unpack.sv
module fp4s_bf16_unpack
    import fp4s_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CODE_W   = 4,
    parameter int SCALE_W  = 8,
    parameter int EXP_BIAS = 126,
    parameter int EXP_MAX  = 255
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_byte,
    input  logic [SCALE_W-1:0] in_scale,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [15:0]        out_word
);
    localparam int N_CODES = DATA_W / CODE_W;
    localparam int SEL_W   = (N_CODES > 1) ? $clog2(N_CODES) : 1;

    logic [DATA_W-1:0]     held_data;
    logic [SCALE_W-1:0]    held_scale;
    logic [SEL_W-1:0]      sel;
    fp4_code_t             code;
    logic [BF16_EXP_W-1:0] exp_scaled;
    logic                  exp_sat;
    bf16_word_t            word_d;

    fp4s_beat_ctrl #(
        .DATA_W (DATA_W),
        .SCALE_W(SCALE_W),
        .N_CODES(N_CODES),
        .SEL_W  (SEL_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid),
        .in_ready_o (in_ready),
        .data_i     (in_byte),
        .scale_i    (in_scale),
        .out_valid_o(out_valid),
        .out_ready_i(out_ready),
        .data_o     (held_data),
        .scale_o    (held_scale),
        .sel_o      (sel)
    );

    fp4s_code_pick #(
        .DATA_W(DATA_W),
        .CODE_W(CODE_W),
        .SEL_W (SEL_W)
    ) u_pick (
        .data_i(held_data),
        .sel_i (sel),
        .code_o(code)
    );

    fp4s_exp_rebase #(
        .SCALE_W (SCALE_W),
        .EXP_BIAS(EXP_BIAS),
        .EXP_MAX (EXP_MAX)
    ) u_rebase (
        .code_exp_i(code.exp),
        .scale_i   (held_scale),
        .exp_o     (exp_scaled),
        .sat_o     (exp_sat)
    );

    always_comb begin
        word_d.sign = code.sign;
        word_d.exp  = exp_scaled;
        word_d.man  = {code.man, {(BF16_MAN_W-1){1'b0}}};
        out_word    = word_d;
    end

    // R9: a stalled word does not move
    p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    // R5: only the top mantissa bit can be set
    p_low_man_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_word[5:0] == 6'd0));

    // R6: no code maps below the bias, so no zero case exists
    p_exp_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_word[14:7] >= BF16_EXP_W'(EXP_BIAS)));

    // R7: full scale or an overflowing sum pins the exponent at its top
    p_sat_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (exp_sat || (&held_scale))) |-> (out_word[14:7] == BF16_EXP_W'(EXP_MAX)));

endmodule

// File: tb/fp4s_bf16_unpack_tb_top.sv
module fp4s_bf16_unpack_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_byte;
    logic [7:0]  in_scale;
    logic        out_valid;
    logic        out_ready;
    logic [15:0] out_word;

    fp4s_bf16_unpack dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_byte  (in_byte),
        .in_scale (in_scale),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_word (out_word)
    );

    int          checks = 0;
    int          errors = 0;
    int          beats = 0;
    int          bytes_sent = 0;
    int          rmode = 0;
    logic [7:0]  lfsr = 8'hB5;
    logic [15:0] exp_q[$];

    function automatic logic [15:0] model(logic [3:0] c, logic [7:0] s);
        int e;
        e = int'(c[2:1]) + 126 + int'(s);
        if (e > 255) e = 255;
        return {c[3], e[7:0], c[0], 6'b0};
    endfunction

    task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    // Ready pattern: 0 always high, 1 pseudo-random, 2 held low
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (rmode)
            0:       out_ready <= 1'b1;
            1:       out_ready <= lfsr[2] | lfsr[6];
            default: out_ready <= 1'b0;
        endcase
    end

    // Monitor: samples one time unit before each rising edge
    always @(negedge clk) begin
        #4;
        if (rst_n && out_valid && out_ready) begin
            beats++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected beat", out_word, 16'h0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                // R2 order, R3 sign, R4 exponent, R5 mantissa, R7 clamp
                chk(out_word == e, "R2 R3 R4 R5 R7 word", out_word, e);
            end
        end
    end

    task automatic send(logic [7:0] b, logic [7:0] s);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        in_scale = s;
        forever begin
            #4;
            if (in_ready) break;
            @(negedge clk);
        end
        exp_q.push_back(model(b[3:0], s));
        exp_q.push_back(model(b[7:4], s));
        bytes_sent++;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_byte  = 8'h33;
        in_scale = 8'h00;
        repeat (4) @(negedge clk);
        #4;
        chk(out_valid == 1'b0, "R1 out_valid in reset", {15'd0, out_valid}, 16'h0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        #4;
        chk(in_ready == 1'b1, "R1 in_ready after reset", {15'd0, in_ready}, 16'h1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", {15'd0, out_valid}, 16'h0);

        // R6: zero exponent field still gets the bias
        send(8'h00, 8'd0);
        idle();
        #4;
        chk(out_valid && out_word == 16'h3F00, "R6 code 0 scale 0", out_word, 16'h3F00);
        drain();

        // R7: saturation from a full scale
        send(8'hFF, 8'd255);
        idle();
        #4;
        chk(out_valid && out_word == 16'hFFC0, "R7 full scale", out_word, 16'hFFC0);
        drain();

        // R7: sum just above and just below the top
        send(8'h06, 8'd127);
        idle();
        #4;
        chk(out_valid && out_word == 16'h7F80, "R7 sum 256", out_word, 16'h7F80);
        drain();

        // R3: sign in the high code only
        send(8'h80, 8'd1);
        send(8'h08, 8'd1);
        idle();
        drain();

        // Back-to-back sweep of every byte value, ready always high
        for (int b = 0; b < 256; b++) begin
            send(8'(b), 8'((b * 37) & 255));
        end
        idle();
        drain();

        // Random back-pressure sweep
        rmode = 1;
        for (int b = 0; b < 64; b++) begin
            send(8'(b * 5 + 3), 8'(b ^ 8'hA5));
        end
        idle();
        rmode = 0;
        drain();

        // R8, R9 and R2 under a held stall
        rmode = 2;
        @(negedge clk);
        @(negedge clk);
        send(8'h5A, 8'd10);
        // keep a second byte waiting at the input during the stall
        @(negedge clk);
        in_byte  = 8'h11;
        in_scale = 8'd3;
        for (int k = 0; k < 3; k++) begin
            #4;
            chk(in_ready == 1'b0, "R8 input closed while held", {15'd0, in_ready}, 16'h0);
            chk(out_valid == 1'b1, "R9 valid held", {15'd0, out_valid}, 16'h1);
            chk(out_word == 16'hC480, "R2 R9 low code first and stable", out_word, 16'hC480);
            @(negedge clk);
        end
        in_valid = 1'b0;
        rmode = 0;
        drain();

        // R10: two transfers per accepted byte
        chk(beats == 2 * bytes_sent, "R10 beat count", 16'(beats), 16'(2 * bytes_sent));

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule